// File: doc/BRIEF.md
# Short Pulse Capture Sticky Flag

This block turns a brief request strobe from a slower, unrelated clock domain into a sticky pending flag that a fast processor can poll. The strobe may last only a single period of its source clock, about six periods of the fast clock. It is passed through a flop synchroniser, and its rising edge is detected in the fast domain. Each edge produces one event: the pending flag is set and an event counter advances by one. Holding the input high longer never produces a second event.

The processor reads the flag and acknowledges it with a single-cycle clear write. A new edge that arrives in the same cycle as a clear wins, so that request stays pending and is not lost. An edge that arrives while the flag is still pending sets a sticky overrun bit, which the same clear write removes. The flag itself is the level request that goes to the processor.

Top module: `pulse_capture_flag`

## Requirements
- R1: After synchronous reset, flag_o is 0, overrun_o is 0 and evt_count_o is 0.
- R2: When req_async goes high just after a rising clk edge, flag_o is still 0 after the second rising edge and reads 1 after the third rising edge that follows.
- R3: evt_count_o increments by exactly one for each low-to-high transition of req_async, whatever the pulse width, provided each level is held for at least one clk period.
- R4: Once set, flag_o stays 1 for as long as no clear write is made, regardless of further activity on req_async.
- R5: A clear write (clr_wr high for one cycle) in a cycle with no detected edge makes flag_o 0 from the next cycle on.
- R6: When a detected edge and a clear write fall in the same cycle, flag_o is 1 and overrun_o is 0 afterwards.
- R7: A detected edge while flag_o is already 1 and no clear is written sets overrun_o to 1, and it stays 1 until a clear write. overrun_o is never 1 while flag_o is 0.
- R8: A clear write makes overrun_o 0 in the next cycle.
- R9: While req_async stays at a constant level, evt_count_o does not change, and after a clear flag_o stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast processor-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| req_async | input | 1 | Request strobe from the foreign clock domain |
| clr_wr | input | 1 | Single-cycle processor write that acknowledges the flag |
| flag_o | output | 1 | Sticky pending request, also used as the level request |
| overrun_o | output | 1 | Sticky: an edge arrived while a request was still pending |
| evt_count_o | output | 16 | Count of detected request edges, wrapping |

## Verification
The assertions assume that req_async holds each level for at least one clk period, so every transition is sampled, and that clr_wr is a synchronous strobe. The bench changes req_async and clr_wr only on falling clk edges, with pulse widths and gaps of at least one clock period. It sweeps widths, gaps and bursts, and it slides the clear write across the cycle in which the edge is detected, so the priority between clear and edge is exercised from both sides.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

    localparam int CNT_W_DEF       = 16;
    localparam int SYNC_STAGES_DEF = 2;

    typedef struct packed {
        logic pending;
        logic overrun;
    } flag_state_t;

    localparam flag_state_t FLAG_IDLE = '{pending: 1'b0, overrun: 1'b0};

    // Next state of the sticky pair: a new edge beats a clear in the same cycle.
    function automatic flag_state_t flag_next(flag_state_t cur, logic hit, logic ack);
        flag_state_t n;
        n.pending = hit | (cur.pending & ~ack);
        n.overrun = ack ? 1'b0 : (cur.overrun | (hit & cur.pending));
        return n;
    endfunction

endpackage

// File: rtl/pcap_sync.sv
module pcap_sync #(
    parameter int STAGES = pcap_pkg::SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("pcap_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/pcap_edge.sv
module pcap_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    assign rise = lvl & ~prev;
endmodule

// File: rtl/pcap_flag.sv
module pcap_flag
    import pcap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        hit,
    input  logic        ack,
    output flag_state_t state
);
    always_ff @(posedge clk) begin
        if (rst) state <= FLAG_IDLE;
        else     state <= flag_next(state, hit, ack);
    end

    assert_edge_sets_R2: assert property (@(posedge clk) disable iff (rst)
        hit |=> state.pending);
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        state.pending && !ack |=> state.pending);
    assert_clear_wins_R5: assert property (@(posedge clk) disable iff (rst)
        ack && !hit |=> !state.pending);
    assert_same_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        ack && hit |=> state.pending && !state.overrun);
    assert_overrun_set_R7: assert property (@(posedge clk) disable iff (rst)
        hit && state.pending && !ack |=> state.overrun);
    assert_overrun_clear_R8: assert property (@(posedge clk) disable iff (rst)
        ack |=> !state.overrun);
endmodule

// File: rtl/pcap_counter.sv
module pcap_counter #(
    parameter int CNT_W = pcap_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)      count <= '0;
        else if (inc) count <= count + CNT_W'(1);
    end

    assert_one_step_R3: assert property (@(posedge clk) disable iff (rst)
        inc |=> count == $past(count) + CNT_W'(1));
    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(count));
endmodule

// File: rtl/pulse_capture_flag.sv
module pulse_capture_flag
    import pcap_pkg::*;
#(
    parameter int CNT_W       = CNT_W_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_async,
    input  logic             clr_wr,
    output logic             flag_o,
    output logic             overrun_o,
    output logic [CNT_W-1:0] evt_count_o
);
    logic        req_sync;
    logic        req_rise;
    flag_state_t fstate;

    pcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (req_async),
        .dout (req_sync)
    );

    pcap_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (req_sync),
        .rise (req_rise)
    );

    pcap_flag u_flag (
        .clk   (clk),
        .rst   (rst),
        .hit   (req_rise),
        .ack   (clr_wr),
        .state (fstate)
    );

    pcap_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (req_rise),
        .count (evt_count_o)
    );

    assign flag_o    = fstate.pending;
    assign overrun_o = fstate.overrun;

    assert_overrun_needs_flag_R7: assert property (@(posedge clk) disable iff (rst)
        overrun_o |-> flag_o);
    assert_no_double_event_R3: assert property (@(posedge clk) disable iff (rst)
        req_rise |=> !req_rise);
endmodule

// File: tb/tb_pulse_capture_flag.sv
module tb_pulse_capture_flag;
    localparam int CLK_PERIOD = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_async = 1'b0;
    logic        clr_wr = 1'b0;
    logic        flag_o;
    logic        overrun_o;
    logic [15:0] evt_count_o;

    int total = 0;
    int bad   = 0;
    int exp_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_capture_flag dut (
        .clk         (clk),
        .rst         (rst),
        .req_async   (req_async),
        .clr_wr      (clr_wr),
        .flag_o      (flag_o),
        .overrun_o   (overrun_o),
        .evt_count_o (evt_count_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic pulse(input int width, input int gap);
        req_async = 1'b1;
        tick(width);
        req_async = 1'b0;
        tick(gap);
        exp_cnt++;
    endtask

    task automatic clear_once();
        clr_wr = 1'b1;
        tick(1);
        clr_wr = 1'b0;
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        check("R1 flag after reset", int'(flag_o), 0);
        check("R1 overrun after reset", int'(overrun_o), 0);
        check("R1 count after reset", int'(evt_count_o), 0);

        // R2 latency: raised at a falling edge, pending after the third rising edge
        req_async = 1'b1;
        tick(2);
        check("R2 flag still low after two edges", int'(flag_o), 0);
        tick(1);
        check("R2 flag high after three edges", int'(flag_o), 1);
        req_async = 1'b0;
        tick(2);
        exp_cnt++;
        check("R3 count after first pulse", int'(evt_count_o), exp_cnt);
        clear_once();
        check("R5 flag cleared", int'(flag_o), 0);

        // R3/R5 sweep over widths and gaps
        for (int w = 1; w <= 8; w++) begin
            for (int g = 1; g <= 4; g++) begin
                pulse(w, g);
                tick(3);
                check("R3 count per pulse", int'(evt_count_o), exp_cnt);
                check("R2 flag set by pulse", int'(flag_o), 1);
                check("R7 no overrun on single pulse", int'(overrun_o), 0);
                clear_once();
                check("R5 flag cleared after pulse", int'(flag_o), 0);
            end
        end

        // R4/R7/R8 bursts without a clear
        for (int k = 2; k <= 5; k++) begin
            for (int i = 0; i < k; i++) pulse(6, 2);
            tick(3);
            check("R3 count after burst", int'(evt_count_o), exp_cnt);
            check("R7 overrun after burst", int'(overrun_o), 1);
            tick(10);
            check("R4 flag held without clear", int'(flag_o), 1);
            check("R7 overrun held without clear", int'(overrun_o), 1);
            clear_once();
            check("R8 overrun cleared", int'(overrun_o), 0);
            check("R5 flag cleared after burst", int'(flag_o), 0);
        end

        // R9 long high level gives one event only
        req_async = 1'b1;
        tick(6);
        exp_cnt++;
        check("R3 one event on long level", int'(evt_count_o), exp_cnt);
        clear_once();
        tick(40);
        check("R9 count stable on steady high", int'(evt_count_o), exp_cnt);
        check("R9 flag stays low on steady high", int'(flag_o), 0);
        req_async = 1'b0;
        tick(40);
        check("R9 count stable on steady low", int'(evt_count_o), exp_cnt);

        // R6 slide the clear across the edge-detect cycle (cycle 3), flag already pending
        for (int d = -2; d <= 2; d++) begin
            pulse(3, 1);
            tick(3);
            req_async = 1'b1;
            for (int c = 1; c <= 6; c++) begin
                clr_wr = (c == 3 + d);
                if (c == 3) req_async = 1'b0;
                tick(1);
            end
            clr_wr = 1'b0;
            exp_cnt++;
            check("R6 flag vs clear offset", int'(flag_o), (d <= 0) ? 1 : 0);
            check("R6 overrun vs clear offset", int'(overrun_o), 0);
            check("R3 count with clear offset", int'(evt_count_o), exp_cnt);
            clear_once();
            tick(2);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule